// File: doc/BRIEF.md
# ATA PIO Strobe Timing Generator

This block produces programmed-I/O register cycles for a parallel ATA host that drives two channels, each of which carries a master and a slave device. A host-side request names the channel, the device, the direction, whether the access is a command-register access or a data access, and the register index within the command block. The block then runs one bus cycle with three phases. The first is a fixed one-clock address setup. The second is a strobe-low phase. The third is a recovery phase with the strobe high. When the cycle ends, the block pulses `done`.

The lengths of the strobe and recovery phases come from a byte-wide timing register file. The low nibble of each timing byte is the strobe clock count and the high nibble is the recovery clock count. Each channel owns one byte for command-register accesses. Each channel and device pair owns one byte for data reads and one byte for data writes. A control byte gates the two channels and holds a DMA-mode flag. The DMA-mode flag is stored and brought out, but it has no effect on PIO cycles.

Read data is captured on the edge where the strobe rises. Write data is driven for the whole cycle. While a cycle runs, `busy` is high and new requests are dropped.

Top module: `ata_pio_strobe_gen`

## Requirements
- R1: After reset, every timing byte reads 0xB6, which means a strobe of 6 clocks and a recovery of 11 clocks. The control byte reads 0x03: both channels are enabled and the DMA flag (bit 6) is clear.
- R2: The register map with the default base 0x60 is as follows. The control byte is at 0x60. It stores only bit 0 (channel 0 enable), bit 1 (channel 1 enable) and bit 6 (DMA flag), and its other bits read 0. The command timing byte for channel c is at 0x62+c. Unmapped offsets read 0 and ignore writes.
- R3: An accepted cycle runs in this order. First comes one setup clock with chip select low and both strobes high. Next the strobe is low for the strobe count, taken from bits 3:0. Then come the recovery clocks, taken from bits 7:4, with the strobe high and chip select still low. In the following clock, `done` is high for exactly one clock, and `busy` and chip select are already released. The register index is on `bus_addr` for the whole cycle.
- R4: A nibble value of 0 gives a phase length of one clock.
- R5: Command accesses (`req_cmd`=1) take their timing from the channel's command byte, whatever the device and direction.
- R6: Data reads take their timing from offset 0x64+4c+d. Data writes take their timing from offset 0x66+4c+d.
- R7: For a read, `rdata` takes `bus_din` on the edge where the strobe rises. It holds that value until the next read capture.
- R8: For a write, `bus_oe` is high and `bus_dout` carries the request data from the setup clock through the last recovery clock. At all other times `bus_oe` is low.
- R9: A request to a channel whose enable bit is clear is dropped. No `busy`, chip select, strobe or `done` follows it.
- R10: `busy` is high from the setup clock through the last recovery clock. Requests presented while `busy` is high are dropped.
- R11: Only the addressed channel's chip select and strobes move. Reads use the read strobe and writes use the write strobe. At most one strobe is low at any time.
- R12: The timing is captured when the request is accepted. A write to a timing byte during a cycle does not change that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Timing/control byte write enable |
| cfg_addr | input | 8 | Configuration byte offset for write and readback |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Readback of the byte at `cfg_addr` |
| req_valid | input | 1 | Cycle request strobe |
| req_chan | input | 1 | Channel of the request |
| req_dev | input | 1 | Device on the channel (0 master, 1 slave) |
| req_write | input | 1 | 1 for a write cycle, 0 for a read cycle |
| req_cmd | input | 1 | 1 selects command timing, 0 selects per-device data timing |
| req_reg | input | 3 | Register index within the command block |
| req_wdata | input | 16 | Write data |
| busy | output | 1 | Cycle in progress |
| done | output | 1 | One-clock end-of-cycle pulse |
| rdata | output | 16 | Last captured read data |
| dma_en | output | 1 | Stored DMA-mode flag |
| bus_addr | output | 3 | Register address to the drive |
| bus_dout | output | 16 | Write data to the drive |
| bus_oe | output | 1 | Data output enable |
| bus_din | input | 16 | Data from the drive |
| cs_n | output | 2 | Per-channel command-block select, active low |
| rd_n | output | 2 | Per-channel read strobe, active low |
| wr_n | output | 2 | Per-channel write strobe, active low |

## Verification
The bench builds the block with its default parameters: 16-bit data, base offset 0x60 and a 3-bit register index. With these values the full nibble range 0 to 15 is within reach, so the zero clamp, the one-clock strobe and the longest reset timing are all reachable. `bus_din` changes on every clock, so capturing a clock early or late shows up as a wrong `rdata` value. Distinct timing bytes are written to every channel, device and direction. The measured strobe and chip-select lengths therefore show whether the right byte was chosen.

// File: rtl/ata_pio_pkg.sv
// Shared types and constants for the ATA PIO strobe generator.
// Assumes two channels with two devices each and byte-wide timing registers.
package ata_pio_pkg;
    localparam int NCHAN = 2;
    localparam int NDEV  = 2;
    localparam int CH_W  = $clog2(NCHAN);
    localparam int DV_W  = $clog2(NDEV);

    typedef enum logic [1:0] {PH_IDLE, PH_SETUP, PH_ASSERT, PH_RECOV} phase_e;

    // Timing byte: recovery in the upper nibble, strobe width in the lower.
    typedef struct packed {
        logic [3:0] recov;
        logic [3:0] strobe;
    } tbyte_t;

    localparam logic [7:0] TB_RESET   = 8'hB6;
    localparam logic [7:0] CTRL_RESET = 8'h03;
    localparam logic [7:0] CTRL_MASK  = 8'h43;

    // A zero nibble still lasts one clock.
    function automatic logic [3:0] nib_count(logic [3:0] n);
        return (n == 4'd0) ? 4'd1 : n;
    endfunction
endpackage

// File: rtl/ata_timing_regs.sv
// Byte-wide timing and control register file.
// Holds per-channel command timing, per-device read/write timing and the
// channel/DMA control byte; presents the timing byte a request selects.
// Assumes one write port and combinational readback.
module ata_timing_regs
    import ata_pio_pkg::*;
#(
    parameter int              ADDR_W   = 8,
    parameter logic [ADDR_W-1:0] CFG_BASE = 8'h60
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [7:0]        cfg_wdata,
    output logic [7:0]        cfg_rdata,
    input  logic [CH_W-1:0]   sel_chan,
    input  logic [DV_W-1:0]   sel_dev,
    input  logic              sel_write,
    input  logic              sel_cmd,
    output tbyte_t            sel_timing,
    output logic [NCHAN-1:0]  chan_en,
    output logic              dma_en
);
    localparam logic [ADDR_W-1:0] CTRL_OFF = CFG_BASE;

    function automatic logic [ADDR_W-1:0] cmd_off(int c);
        return ADDR_W'(int'(CFG_BASE) + 2 + c);
    endfunction
    function automatic logic [ADDR_W-1:0] rd_off(int c, int d);
        return ADDR_W'(int'(CFG_BASE) + 4 + 4*c + d);
    endfunction
    function automatic logic [ADDR_W-1:0] wr_off(int c, int d);
        return ADDR_W'(int'(CFG_BASE) + 6 + 4*c + d);
    endfunction

    logic [7:0] ctrl_q;
    logic [7:0] cmd_q [NCHAN];
    logic [7:0] rdt_q [NCHAN][NDEV];
    logic [7:0] wrt_q [NCHAN][NDEV];

    // Register writes with reset to mode-0 timing and both channels enabled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= CTRL_RESET;
            for (int c = 0; c < NCHAN; c++) begin
                cmd_q[c] <= TB_RESET;
                for (int d = 0; d < NDEV; d++) begin
                    rdt_q[c][d] <= TB_RESET;
                    wrt_q[c][d] <= TB_RESET;
                end
            end
        end else if (cfg_we) begin
            if (cfg_addr == CTRL_OFF) ctrl_q <= cfg_wdata & CTRL_MASK;
            for (int c = 0; c < NCHAN; c++) begin
                if (cfg_addr == cmd_off(c)) cmd_q[c] <= cfg_wdata;
                for (int d = 0; d < NDEV; d++) begin
                    if (cfg_addr == rd_off(c, d)) rdt_q[c][d] <= cfg_wdata;
                    if (cfg_addr == wr_off(c, d)) wrt_q[c][d] <= cfg_wdata;
                end
            end
        end
    end

    // Readback mux; unmapped offsets return zero.
    always_comb begin
        cfg_rdata = '0;
        if (cfg_addr == CTRL_OFF) cfg_rdata = ctrl_q;
        for (int c = 0; c < NCHAN; c++) begin
            if (cfg_addr == cmd_off(c)) cfg_rdata = cmd_q[c];
            for (int d = 0; d < NDEV; d++) begin
                if (cfg_addr == rd_off(c, d)) cfg_rdata = rdt_q[c][d];
                if (cfg_addr == wr_off(c, d)) cfg_rdata = wrt_q[c][d];
            end
        end
    end

    // Timing byte chosen by the request attributes.
    always_comb begin
        if (sel_cmd)        sel_timing = cmd_q[sel_chan];
        else if (sel_write) sel_timing = wrt_q[sel_chan][sel_dev];
        else                sel_timing = rdt_q[sel_chan][sel_dev];
    end

    assign chan_en = ctrl_q[NCHAN-1:0];
    assign dma_en  = ctrl_q[6];

    // R2: only the defined control bits are kept.
    p_ctrl_mask_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_addr == CTRL_OFF) |=> (ctrl_q == ($past(cfg_wdata) & CTRL_MASK)));
endmodule

// File: rtl/ata_strobe_seq.sv
// Cycle sequencer: setup, strobe, recovery, then a done pulse.
// Latches the request and its timing at acceptance; assumes the timing
// byte presented with the request is valid in the same clock.
module ata_strobe_seq
    import ata_pio_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int REG_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [CH_W-1:0]   req_chan,
    input  logic              req_write,
    input  logic [REG_W-1:0]  req_reg,
    input  logic [DATA_W-1:0] req_wdata,
    input  tbyte_t            timing,
    input  logic [NCHAN-1:0]  chan_en,
    input  logic [DATA_W-1:0] bus_din,
    output phase_e            phase,
    output logic [CH_W-1:0]   cur_chan,
    output logic              cur_write,
    output logic              busy,
    output logic              done,
    output logic [REG_W-1:0]  bus_addr,
    output logic [DATA_W-1:0] bus_dout,
    output logic              bus_oe,
    output logic [DATA_W-1:0] rdata
);
    logic [3:0]        cnt;
    logic [3:0]        lat_strobe;
    logic [3:0]        lat_recov;
    logic [REG_W-1:0]  lat_reg;
    logic [DATA_W-1:0] lat_wdata;
    logic              accept;

    // Request taken only when idle and the channel is enabled.
    assign accept = (phase == PH_IDLE) && req_valid && chan_en[req_chan];

    // Phase state machine with per-phase down counter and read capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase      <= PH_IDLE;
            cnt        <= '0;
            done       <= 1'b0;
            cur_chan   <= '0;
            cur_write  <= 1'b0;
            lat_strobe <= 4'd1;
            lat_recov  <= 4'd1;
            lat_reg    <= '0;
            lat_wdata  <= '0;
            rdata      <= '0;
        end else begin
            done <= 1'b0;
            unique case (phase)
                PH_IDLE: if (accept) begin
                    phase      <= PH_SETUP;
                    cur_chan   <= req_chan;
                    cur_write  <= req_write;
                    lat_reg    <= req_reg;
                    lat_wdata  <= req_wdata;
                    lat_strobe <= nib_count(timing.strobe);
                    lat_recov  <= nib_count(timing.recov);
                end
                PH_SETUP: begin
                    phase <= PH_ASSERT;
                    cnt   <= lat_strobe - 4'd1;
                end
                PH_ASSERT: begin
                    if (cnt == 4'd0) begin
                        phase <= PH_RECOV;
                        cnt   <= lat_recov - 4'd1;
                        if (!cur_write) rdata <= bus_din;
                    end else begin
                        cnt <= cnt - 4'd1;
                    end
                end
                PH_RECOV: begin
                    if (cnt == 4'd0) begin
                        phase <= PH_IDLE;
                        done  <= 1'b1;
                    end else begin
                        cnt <= cnt - 4'd1;
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    assign busy     = (phase != PH_IDLE);
    assign bus_oe   = busy && cur_write;
    assign bus_dout = bus_oe ? lat_wdata : '0;
    assign bus_addr = busy ? lat_reg : '0;

    // R3: done follows the last recovery clock and lasts one clock.
    p_done_after_recov_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(phase) == PH_RECOV && phase == PH_IDLE));
    p_done_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R12: latched timing holds for the whole cycle.
    p_timing_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> ($stable(lat_strobe) && $stable(lat_recov)));
    // R10: a running cycle is never restarted by a request.
    p_no_restart_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_ASSERT) |=> (phase != PH_SETUP));
endmodule

// File: rtl/ata_pio_strobe_gen.sv
// Top: two-channel ATA PIO strobe timing generator.
// Joins the timing register file and the sequencer and fans the active
// cycle out to per-channel chip select and strobes. Assumes one cycle at a
// time across both channels.
module ata_pio_strobe_gen
    import ata_pio_pkg::*;
#(
    parameter int              DATA_W   = 16,
    parameter int              ADDR_W   = 8,
    parameter int              REG_W    = 3,
    parameter logic [ADDR_W-1:0] CFG_BASE = 8'h60
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [7:0]        cfg_wdata,
    output logic [7:0]        cfg_rdata,
    input  logic              req_valid,
    input  logic [CH_W-1:0]   req_chan,
    input  logic [DV_W-1:0]   req_dev,
    input  logic              req_write,
    input  logic              req_cmd,
    input  logic [REG_W-1:0]  req_reg,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] rdata,
    output logic              dma_en,
    output logic [REG_W-1:0]  bus_addr,
    output logic [DATA_W-1:0] bus_dout,
    output logic              bus_oe,
    input  logic [DATA_W-1:0] bus_din,
    output logic [NCHAN-1:0]  cs_n,
    output logic [NCHAN-1:0]  rd_n,
    output logic [NCHAN-1:0]  wr_n
);
    tbyte_t           sel_timing;
    logic [NCHAN-1:0] chan_en;
    phase_e           phase;
    logic [CH_W-1:0]  cur_chan;
    logic             cur_write;

    ata_timing_regs #(.ADDR_W(ADDR_W), .CFG_BASE(CFG_BASE)) u_regs (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .sel_chan(req_chan),
        .sel_dev(req_dev), .sel_write(req_write), .sel_cmd(req_cmd),
        .sel_timing(sel_timing), .chan_en(chan_en), .dma_en(dma_en)
    );

    ata_strobe_seq #(.DATA_W(DATA_W), .REG_W(REG_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_chan(req_chan),
        .req_write(req_write), .req_reg(req_reg), .req_wdata(req_wdata),
        .timing(sel_timing), .chan_en(chan_en), .bus_din(bus_din),
        .phase(phase), .cur_chan(cur_chan), .cur_write(cur_write),
        .busy(busy), .done(done), .bus_addr(bus_addr), .bus_dout(bus_dout),
        .bus_oe(bus_oe), .rdata(rdata)
    );

    // Per-channel select and strobe decode.
    for (genvar c = 0; c < NCHAN; c++) begin : g_chan
        logic hit;
        assign hit     = busy && (cur_chan == CH_W'(c));
        assign cs_n[c] = !hit;
        assign rd_n[c] = !(hit && phase == PH_ASSERT && !cur_write);
        assign wr_n[c] = !(hit && phase == PH_ASSERT && cur_write);
    end

    // R11: at most one strobe low anywhere.
    p_one_strobe_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~{rd_n, wr_n}));
    // R3: a low strobe always has its chip select low.
    p_strobe_has_cs_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (((~rd_n) | (~wr_n)) & cs_n) == '0);
    // R9: a request to a disabled channel starts nothing.
    p_disabled_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && req_valid && !chan_en[req_chan]) |=> !busy);
endmodule

// File: tb/ata_pio_strobe_gen_tb.sv
`timescale 1ns/1ps
module ata_pio_strobe_gen_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [7:0]  cfg_addr = 8'h00;
    logic [7:0]  cfg_wdata = 8'h00;
    logic [7:0]  cfg_rdata;
    logic        req_valid = 1'b0;
    logic        req_chan = 1'b0;
    logic        req_dev = 1'b0;
    logic        req_write = 1'b0;
    logic        req_cmd = 1'b0;
    logic [2:0]  req_reg = 3'd0;
    logic [15:0] req_wdata = 16'h0;
    logic        busy, done, dma_en, bus_oe;
    logic [15:0] rdata, bus_dout;
    logic [15:0] bus_din = 16'h1234;
    logic [2:0]  bus_addr;
    logic [1:0]  cs_n, rd_n, wr_n;

    int errors = 0;
    int checks = 0;
    bit started = 1'b0;

    always #4 clk = ~clk;

    ata_pio_strobe_gen u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .req_valid(req_valid),
        .req_chan(req_chan), .req_dev(req_dev), .req_write(req_write),
        .req_cmd(req_cmd), .req_reg(req_reg), .req_wdata(req_wdata),
        .busy(busy), .done(done), .rdata(rdata), .dma_en(dma_en),
        .bus_addr(bus_addr), .bus_dout(bus_dout), .bus_oe(bus_oe),
        .bus_din(bus_din), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n)
    );

    task automatic chk(string tag, longint act, longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    logic [7:0]  m_ctrl;
    logic [7:0]  m_cmd [2];
    logic [7:0]  m_rdt [2][2];
    logic [7:0]  m_wrt [2][2];
    int          m_st, m_n, m_a, m_r;
    bit          m_ch, m_wr, m_done;
    logic [2:0]  m_reg;
    logic [15:0] m_wd, m_rdata;

    function automatic int cnt_of(logic [3:0] n);
        return (n == 0) ? 1 : int'(n);
    endfunction

    function automatic logic [7:0] m_read(logic [7:0] a);
        if (a == 8'h60) return m_ctrl;
        for (int c = 0; c < 2; c++) begin
            if (a == 8'(8'h62 + c)) return m_cmd[c];
            for (int d = 0; d < 2; d++) begin
                if (a == 8'(8'h64 + 4*c + d)) return m_rdt[c][d];
                if (a == 8'(8'h66 + 4*c + d)) return m_wrt[c][d];
            end
        end
        return 8'h00;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_ctrl = 8'h03; m_st = 0; m_n = 0; m_done = 0; m_rdata = 0;
            m_ch = 0; m_wr = 0; m_reg = 0; m_wd = 0; m_a = 1; m_r = 1;
            for (int c = 0; c < 2; c++) begin
                m_cmd[c] = 8'hB6;
                for (int d = 0; d < 2; d++) begin m_rdt[c][d] = 8'hB6; m_wrt[c][d] = 8'hB6; end
            end
        end else begin
            m_done = 0;
            case (m_st)
                0: if (req_valid && m_ctrl[req_chan]) begin
                    logic [7:0] t;
                    t = req_cmd ? m_cmd[req_chan] :
                        (req_write ? m_wrt[req_chan][req_dev] : m_rdt[req_chan][req_dev]);
                    m_a = cnt_of(t[3:0]); m_r = cnt_of(t[7:4]);
                    m_ch = req_chan; m_wr = req_write; m_reg = req_reg; m_wd = req_wdata;
                    m_st = 1;
                end
                1: begin m_st = 2; m_n = m_a; end
                2: if (m_n == 1) begin
                       m_st = 3; m_n = m_r;
                       if (!m_wr) m_rdata = bus_din;
                   end else m_n--;
                default: if (m_n == 1) begin m_st = 0; m_done = 1; end else m_n--;
            endcase
            if (cfg_we) begin
                if (cfg_addr == 8'h60) m_ctrl = cfg_wdata & 8'h43;
                for (int c = 0; c < 2; c++) begin
                    if (cfg_addr == 8'(8'h62 + c)) m_cmd[c] = cfg_wdata;
                    for (int d = 0; d < 2; d++) begin
                        if (cfg_addr == 8'(8'h64 + 4*c + d)) m_rdt[c][d] = cfg_wdata;
                        if (cfg_addr == 8'(8'h66 + 4*c + d)) m_wrt[c][d] = cfg_wdata;
                    end
                end
            end
        end
    end

    // Drive data from the drive side changing every clock.
    always @(negedge clk) bus_din <= bus_din + 16'h0111;

    // Compare every clock, away from the active edge.
    always @(negedge clk) begin
        if (rst_n && started) begin
            logic [1:0] e_cs, e_rd, e_wr;
            e_cs = 2'b11; e_rd = 2'b11; e_wr = 2'b11;
            if (m_st != 0) e_cs[m_ch] = 1'b0;
            if (m_st == 2 && !m_wr) e_rd[m_ch] = 1'b0;
            if (m_st == 2 &&  m_wr) e_wr[m_ch] = 1'b0;
            chk("R10 busy", busy, m_st != 0);
            chk("R3 done", done, m_done);
            chk("R11 cs_n", cs_n, e_cs);
            chk("R3 rd_n", rd_n, e_rd);
            chk("R3 wr_n", wr_n, e_wr);
            chk("R3 bus_addr", bus_addr, (m_st != 0) ? m_reg : 3'd0);
            chk("R8 bus_oe", bus_oe, (m_st != 0) && m_wr);
            chk("R8 bus_dout", bus_dout, ((m_st != 0) && m_wr) ? m_wd : 16'h0);
            chk("R7 rdata", rdata, m_rdata);
            chk("R2 cfg_rdata", cfg_rdata, m_read(cfg_addr));
            chk("R2 dma_en", dma_en, m_ctrl[6]);
        end
    end

    // ---------------- stimulus tasks ----------------
    task automatic cfg_write(logic [7:0] a, logic [7:0] v);
        cfg_addr = a; cfg_wdata = v; cfg_we = 1'b1;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // Issue one request and measure strobe-low and select-low clocks.
    task automatic run(string tag, bit ch, bit dv, bit wr, bit cmd, logic [2:0] rg,
                       logic [15:0] wd, int exp_s, int exp_r);
        int s_cnt = 0;
        int c_cnt = 0;
        int guard = 0;
        req_chan = ch; req_dev = dv; req_write = wr; req_cmd = cmd;
        req_reg = rg; req_wdata = wd; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        while (!done && guard < 100) begin
            if (cs_n[ch] == 1'b0) c_cnt++;
            if ((wr ? wr_n[ch] : rd_n[ch]) == 1'b0) s_cnt++;
            @(negedge clk);
            guard++;
        end
        chk({tag, " strobe clocks"}, s_cnt, exp_s);
        chk({tag, " select clocks"}, c_cnt, 1 + exp_s + exp_r);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        started = 1'b1;
        // R1: reset contents
        for (int a = 8'h60; a <= 8'h6C; a++) begin
            logic [7:0] e;
            cfg_addr = 8'(a);
            #1;
            e = (a == 8'h60) ? 8'h03 : ((a >= 8'h62 && a <= 8'h6B) ? 8'hB6 : 8'h00);
            chk("R1 reset byte", cfg_rdata, e);
        end
        chk("R1 dma flag clear", dma_en, 0);
        @(negedge clk);
        run("R1 default timing", 0, 0, 0, 1, 3'd7, 16'h0, 6, 11);

        // R2/R6/R5: distinct bytes per slot
        cfg_write(8'h62, 8'h21); cfg_write(8'h63, 8'h32);
        cfg_write(8'h64, 8'h13); cfg_write(8'h65, 8'h24);
        cfg_write(8'h66, 8'h35); cfg_write(8'h67, 8'h41);
        cfg_write(8'h68, 8'h12); cfg_write(8'h69, 8'h23);
        cfg_write(8'h6A, 8'h31); cfg_write(8'h6B, 8'h14);
        cfg_write(8'h6E, 8'h55);
        cfg_addr = 8'h6E; #1; chk("R2 unmapped reads zero", cfg_rdata, 0);
        run("R5 cmd ch0 read", 0, 1, 0, 1, 3'd1, 16'h0, 1, 2);
        run("R5 cmd ch1 write", 1, 0, 1, 1, 3'd2, 16'hBEEF, 2, 3);
        run("R6 rd ch0 dev0", 0, 0, 0, 0, 3'd0, 16'h0, 3, 1);
        run("R6 rd ch0 dev1", 0, 1, 0, 0, 3'd0, 16'h0, 4, 2);
        run("R6 wr ch0 dev0", 0, 0, 1, 0, 3'd0, 16'hA5A5, 5, 3);
        run("R6 wr ch0 dev1", 0, 1, 1, 0, 3'd0, 16'h5A5A, 1, 4);
        run("R6 rd ch1 dev0", 1, 0, 0, 0, 3'd0, 16'h0, 2, 1);
        run("R6 rd ch1 dev1", 1, 1, 0, 0, 3'd0, 16'h0, 3, 2);
        run("R6 wr ch1 dev0", 1, 0, 1, 0, 3'd0, 16'hC3C3, 1, 3);
        run("R6 wr ch1 dev1", 1, 1, 1, 0, 3'd0, 16'h3C3C, 4, 1);

        // R4: zero nibbles
        cfg_write(8'h64, 8'h00);
        run("R4 both zero", 0, 0, 0, 0, 3'd0, 16'h0, 1, 1);
        cfg_write(8'h65, 8'hF0);
        run("R4 strobe zero", 0, 1, 0, 0, 3'd0, 16'h0, 1, 15);
        cfg_write(8'h65, 8'h0F);
        run("R4 recovery zero", 0, 1, 0, 0, 3'd0, 16'h0, 15, 1);

        // R2: control mask and DMA flag
        cfg_write(8'h60, 8'hFF);
        cfg_addr = 8'h60; #1; chk("R2 control mask", cfg_rdata, 8'h43);
        chk("R2 dma flag set", dma_en, 1);

        // R9: disabled channel ignored
        cfg_write(8'h60, 8'h01);
        req_chan = 1; req_write = 0; req_cmd = 1; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        for (int i = 0; i < 3; i++) begin
            chk("R9 disabled no busy", busy, 0);
            chk("R9 disabled no select", cs_n, 2'b11);
            @(negedge clk);
        end
        run("R9 enabled channel still runs", 0, 0, 0, 1, 3'd4, 16'h0, 1, 2);
        cfg_write(8'h60, 8'h03);

        // R10: request while busy dropped
        req_chan = 0; req_dev = 0; req_write = 1; req_cmd = 0; req_reg = 3'd0;
        req_wdata = 16'h1111; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        @(negedge clk);
        req_chan = 1; req_write = 0; req_cmd = 1; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        while (!done) @(negedge clk);
        @(negedge clk);
        chk("R10 dropped request idle", busy, 0);
        chk("R10 dropped request no select", cs_n, 2'b11);

        // R12: timing byte rewritten mid-cycle
        cfg_write(8'h66, 8'h23);
        req_chan = 0; req_dev = 0; req_write = 1; req_cmd = 0; req_wdata = 16'h7777;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        begin
            int s_cnt = 0;
            cfg_addr = 8'h66; cfg_wdata = 8'h99; cfg_we = 1'b1;
            if (wr_n[0] == 1'b0) s_cnt++;
            @(negedge clk);
            cfg_we = 1'b0;
            while (!done) begin
                if (wr_n[0] == 1'b0) s_cnt++;
                @(negedge clk);
            end
            chk("R12 captured strobe length", s_cnt, 3);
        end
        cfg_addr = 8'h66; #1; chk("R12 new byte stored", cfg_rdata, 8'h99);
        run("R12 next cycle uses new byte", 0, 0, 1, 0, 3'd0, 16'h8888, 9, 9);

        repeat (2) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule